// File: doc/BRIEF.md
# Card Clock and Bit-Rate Tick Generator

This block derives two timing streams from the system clock for a smart-card interface. The first is the card clock pin level, produced by a 16-bit half-period divider: the pin toggles once every `cclk_div_i + 1` system cycles, so its frequency is F_sys / (2 × (cclk_div_i + 1)). The second is the elementary time unit (ETU) of the serial link. A separate 16-bit divider issues a one-cycle `etu_tick_o` at every bit boundary, at a rate of F_sys / (2 × (etu_div_i + 1)). It also issues a one-cycle `etu_half_o` in the middle of each bit, which the receiver uses to sample.

Software normally sets the bit divisor to (clock divisor + 1) × (F / D) − 1. With the usual conversion factors F = 372 and D = 1, one ETU then lasts exactly 372 card-clock periods. The card clock can be parked at a chosen idle level and released again. Both the stop and the release happen only at a half-period boundary, so the pin never shows a shortened high or low phase. Divisor writes are picked up only when a divider reloads. The ETU divider keeps running while the card clock is parked.

Top module: `ckgen_card_rate`

## Requirements
- R1: While `rst_n` is low, and for the first three clock edges after it rises (two edges of reset synchronisation and one divisor load edge), `cclk_o` is 0 and neither tick is asserted.
- R2: While running, `cclk_o` changes level only at a half-period boundary, and every level lasts exactly `cclk_div_i + 1` system cycles. A divisor of 0 toggles the pin on every cycle, which is F_sys/2.
- R3: `etu_tick_o` is a single-cycle pulse that repeats every 2 × (`etu_div_i` + 1) system cycles.
- R4: `etu_half_o` is a single-cycle pulse asserted `etu_div_i` + 1 cycles after each `etu_tick_o`. It never coincides with `etu_tick_o`.
- R5: Each divider samples its divisor input only when it reloads. A change made in the middle of a count leaves the current half-period or ETU unchanged, and the next one uses the new value.
- R6: When `cclk_stop_i` is 1 and `cclk_o` already equals `cclk_idle_lvl_i` at a boundary, the pin holds that level. If the levels differ, the pin completes one more full half-period toggle and then holds.
- R7: After `cclk_stop_i` returns to 0, the pin toggles at the next half-period boundary. Every following level lasts a full `cclk_div_i + 1` cycles.
- R8: The idle level is selectable: `cclk_idle_lvl_i` = 0 parks the pin low, and 1 parks it high.
- R9: With `cclk_div_i` = 0 and `etu_div_i` = 371 ((0+1) × 372 − 1), one ETU spans 744 system cycles and contains exactly 372 rising edges of `cclk_o`.
- R10: `etu_tick_o` keeps firing at its programmed rate while the card clock is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| cclk_div_i | input | 16 | Card clock half-period divisor (half-period = value + 1 cycles) |
| etu_div_i | input | 16 | Bit-rate divisor (ETU = 2 × (value + 1) cycles) |
| cclk_stop_i | input | 1 | Request to park the card clock |
| cclk_idle_lvl_i | input | 1 | Level at which the parked clock rests (0 low, 1 high) |
| cclk_o | output | 1 | Card clock pin level |
| etu_tick_o | output | 1 | One-cycle pulse at each bit boundary |
| etu_half_o | output | 1 | One-cycle pulse at each mid-bit point |

## Verification
The two functions that can fall in the same cycle are the stop/level decision and the divisor reload. Both act on the half-period boundary edge, and a change to the idle level can arrive on that same edge. The bench provokes this while the pin is parked high: in one cycle it flips the idle level to low and changes the clock divisor. The boundary must then complete the old half-period, drop the pin to the new idle level and load the new divisor, all on one edge. A behavioural per-cycle model judges the result. Every cycle the model compares the pin and both ticks, so any out-of-order handling shows up as a mismatch in a specific cycle.

// File: rtl/ckgen_pkg.sv
`timescale 1ns/1ps
package ckgen_pkg;
  localparam int unsigned CKG_DIV_W       = 16;
  localparam int unsigned CKG_SYNC_STAGES = 2;
  typedef logic [CKG_DIV_W-1:0] ckg_div_t;
endpackage

// File: rtl/ckgen_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the internal reset.
module ckgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/ckgen_reload_ctr.sv
`timescale 1ns/1ps
// Up-counter that counts 0..limit and reloads. The limit is captured only
// on a load cycle: the first cycle after reset, or the terminal count.
module ckgen_reload_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] limit_in,
  output logic         run_o,
  output logic         end_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] limit_o
);
  logic         run_q;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] lim_q;
  logic         match;
  logic         load;

  always_comb begin
    match = (cnt_q == lim_q);
    load  = !run_q || match;
    if (load) cnt_d = '0;
    else      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      run_q <= 1'b1;
      cnt_q <= cnt_d;
      if (load) lim_q <= limit_in;
    end
  end

  assign run_o   = run_q;
  assign end_o   = run_q && match;
  assign count_o = cnt_q;
  assign limit_o = lim_q;
endmodule

// File: rtl/ckgen_clk_shaper.sv
`timescale 1ns/1ps
// Pin level register: toggles at a boundary unless parking at idle level.
module ckgen_clk_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic bound_i,
  input  logic stop_i,
  input  logic idle_lvl_i,
  output logic lvl_o
);
  logic lvl_q, lvl_d;
  logic park;
  logic toggle_en;

  always_comb begin
    park      = stop_i && (lvl_q == idle_lvl_i);
    toggle_en = bound_i && !park;
    lvl_d     = toggle_en ? ~lvl_q : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/ckgen_etu_decode.sv
`timescale 1ns/1ps
// Bit-boundary and mid-bit pulses from the ETU counter (limit = 2*div+1).
module ckgen_etu_decode #(
  parameter int unsigned W = 17
) (
  input  logic         run_i,
  input  logic         end_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o,
  output logic         half_o
);
  logic [W-1:0] mid;

  always_comb begin
    mid    = {1'b0, limit_i[W-1:1]};
    tick_o = end_i;
    half_o = run_i && (count_i == mid);
  end
endmodule

// File: rtl/ckgen_card_rate.sv
`timescale 1ns/1ps
module ckgen_card_rate #(
  parameter int unsigned DIV_W       = ckgen_pkg::CKG_DIV_W,
  parameter int unsigned SYNC_STAGES = ckgen_pkg::CKG_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cclk_div_i,
  input  logic [DIV_W-1:0] etu_div_i,
  input  logic             cclk_stop_i,
  input  logic             cclk_idle_lvl_i,
  output logic             cclk_o,
  output logic             etu_tick_o,
  output logic             etu_half_o
);
  localparam int unsigned ETU_W = DIV_W + 1;

  logic             rst_i_n;
  logic             cc_run;
  logic             cc_end;
  logic [DIV_W-1:0] cc_count;
  logic [DIV_W-1:0] cc_limit;
  logic             etu_run;
  logic             etu_end;
  logic [ETU_W-1:0] etu_count;
  logic [ETU_W-1:0] etu_limit;
  logic [ETU_W-1:0] etu_limit_in;

  assign etu_limit_in = {etu_div_i, 1'b1};

  ckgen_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  ckgen_reload_ctr #(.W(DIV_W)) u_cc_ctr (
    .clk(clk), .rst_n(rst_i_n), .limit_in(cclk_div_i),
    .run_o(cc_run), .end_o(cc_end), .count_o(cc_count), .limit_o(cc_limit)
  );

  ckgen_clk_shaper u_shaper (
    .clk(clk), .rst_n(rst_i_n), .bound_i(cc_end),
    .stop_i(cclk_stop_i), .idle_lvl_i(cclk_idle_lvl_i), .lvl_o(cclk_o)
  );

  ckgen_reload_ctr #(.W(ETU_W)) u_etu_ctr (
    .clk(clk), .rst_n(rst_i_n), .limit_in(etu_limit_in),
    .run_o(etu_run), .end_o(etu_end), .count_o(etu_count), .limit_o(etu_limit)
  );

  ckgen_etu_decode #(.W(ETU_W)) u_etu_dec (
    .run_i(etu_run), .end_i(etu_end), .count_i(etu_count),
    .limit_i(etu_limit), .tick_o(etu_tick_o), .half_o(etu_half_o)
  );

  logic unused_ok;
  assign unused_ok = &{1'b0, cc_run, cc_count, cc_limit};
endmodule

// File: rtl/ckgen_card_rate_chk.sv
`timescale 1ns/1ps
module ckgen_card_rate_chk (
  input logic clk,
  input logic rst_n,
  input logic cclk_stop_i,
  input logic cclk_idle_lvl_i,
  input logic cclk_o,
  input logic etu_tick_o,
  input logic etu_half_o,
  input logic cc_end
);
  AST_TICKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(etu_tick_o && etu_half_o)); // R4
  AST_ETU_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    etu_tick_o |=> !etu_tick_o); // R3
  AST_HALF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    etu_half_o |=> !etu_half_o); // R4
  AST_CLK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_end |=> $stable(cclk_o)); // R2
  AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_end && cclk_stop_i && (cclk_o == cclk_idle_lvl_i)) |=> $stable(cclk_o)); // R6
  AST_RUN_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_end && !cclk_stop_i) |=> (cclk_o != $past(cclk_o))); // R7
endmodule

bind ckgen_card_rate ckgen_card_rate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cclk_stop_i(cclk_stop_i),
  .cclk_idle_lvl_i(cclk_idle_lvl_i), .cclk_o(cclk_o),
  .etu_tick_o(etu_tick_o), .etu_half_o(etu_half_o), .cc_end(cc_end)
);

// File: tb/sim_ckgen_card_rate.sv
`timescale 1ns/1ps
module sim_ckgen_card_rate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cdiv = 16'd0;
  logic [15:0] bdiv = 16'd3;
  logic        stop = 1'b0;
  logic        idle = 1'b0;
  logic        cclk, etick, ehalf;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ckgen_card_rate u0 (
    .clk(clk), .rst_n(rst_n), .cclk_div_i(cdiv), .etu_div_i(bdiv),
    .cclk_stop_i(stop), .cclk_idle_lvl_i(idle),
    .cclk_o(cclk), .etu_tick_o(etick), .etu_half_o(ehalf)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, integers only
  int m_s1, m_s2, m_run, m_ccnt, m_clim, m_ecnt, m_elim, m_lvl;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_run = 0; m_ccnt = 0; m_clim = 0;
      m_ecnt = 0; m_elim = 0; m_lvl = 0;
    end else if (m_s2 == 0) begin
      m_s2 = m_s1; m_s1 = 1;
    end else if (m_run == 0) begin
      m_run = 1; m_ccnt = 0; m_clim = int'(cdiv);
      m_ecnt = 0; m_elim = 2 * int'(bdiv) + 1;
    end else begin
      if (m_ccnt == m_clim) begin
        if (!(stop && (m_lvl == int'(idle)))) m_lvl = 1 - m_lvl;
        m_ccnt = 0; m_clim = int'(cdiv);
      end else m_ccnt++;
      if (m_ecnt == m_elim) begin
        m_ecnt = 0; m_elim = 2 * int'(bdiv) + 1;
      end else m_ecnt++;
    end
  end

  // Per-cycle comparison and measurement monitor
  int cyc = 0, last_edge = 0, clk_gap = 0, last_etu = 0, etu_gap = 0;
  int half_off = 0, rises = 0, rises_per_etu = 0, etu_count = 0;
  logic prev_clk = 1'b0;
  always @(negedge clk) begin
    cyc++;
    begin
      int exp_t, exp_h;
      exp_t = (m_run != 0 && m_ecnt == m_elim) ? 1 : 0;
      exp_h = (m_run != 0 && m_ecnt == m_elim / 2) ? 1 : 0;
      check(int'(cclk) == m_lvl, "R2,R6 cclk model", int'(cclk), m_lvl);
      check(int'(etick) == exp_t, "R3 etu_tick model", int'(etick), exp_t);
      check(int'(ehalf) == exp_h, "R4 etu_half model", int'(ehalf), exp_h);
    end
    if (cclk != prev_clk) begin
      clk_gap = cyc - last_edge; last_edge = cyc;
      if (cclk) rises++;
    end
    prev_clk = cclk;
    if (etick) begin
      etu_gap = cyc - last_etu; last_etu = cyc;
      rises_per_etu = rises; rises = 0; etu_count++;
    end
    if (ehalf) half_off = cyc - last_etu;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic wait_etu();
    do @(negedge clk); while (!etick);
    #1;
  endtask
  task automatic wait_half();
    do @(negedge clk); while (!ehalf);
    #1;
  endtask
  task automatic wait_edge();
    logic l;
    l = cclk;
    do @(negedge clk); while (cclk == l);
    #1;
  endtask
  task automatic held_check(input logic lvl, input string tag);
    int changes;
    changes = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      if (cclk != lvl) changes++;
    end
    check(changes == 0, tag, changes, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL all: watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    cycles(5);
    check(cclk == 1'b0 && !etick && !ehalf, "R1 reset outputs", int'(cclk), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cycles(1);
      check(cclk == 1'b0 && !etick && !ehalf, "R1 sync release", int'(cclk), 0);
    end
    cycles(20);
    check(clk_gap == 1, "R2 divisor 0 half-period", clk_gap, 1);
    wait_etu(); wait_etu();
    check(etu_gap == 8, "R3 ETU period div 3", etu_gap, 8);
    wait_half();
    check(half_off == 4, "R4 mid-bit offset", half_off, 4);
    cdiv = 16'd3;
    cycles(30);
    check(clk_gap == 4, "R2 divisor 3 half-period", clk_gap, 4);
    // R5: change divisors in the middle of a count
    wait_etu(); cycles(2); bdiv = 16'd9;
    wait_etu();
    check(etu_gap == 8, "R5 old ETU divisor kept", etu_gap, 8);
    wait_etu();
    check(etu_gap == 20, "R5 new ETU divisor used", etu_gap, 20);
    wait_edge(); cycles(1); cdiv = 16'd1;
    wait_edge();
    check(clk_gap == 4, "R5 old clock divisor kept", clk_gap, 4);
    wait_edge();
    check(clk_gap == 2, "R5 new clock divisor used", clk_gap, 2);
    cdiv = 16'd3;
    cycles(10);
    // R6, R8: park low, R10: ETU continues
    stop = 1'b1; idle = 1'b0;
    cycles(20);
    begin
      int base;
      base = etu_count;
      held_check(1'b0, "R6,R8 parked low");
      check(etu_count > base, "R10 ETU while parked", etu_count - base, 1);
    end
    // R7: restart
    stop = 1'b0;
    wait_edge(); wait_edge();
    check(clk_gap == 4, "R7 full half-period after restart", clk_gap, 4);
    // R8: park high
    idle = 1'b1; stop = 1'b1;
    cycles(20);
    held_check(1'b1, "R8 parked high");
    // R5, R6 same boundary: idle flip and divisor change together
    idle = 1'b0; cdiv = 16'd0;
    cycles(20);
    check(cclk == 1'b0, "R6 reparked at new idle", int'(cclk), 0);
    stop = 1'b0;
    // R9: F/D relation
    bdiv = 16'd371;
    wait_etu(); wait_etu(); wait_etu();
    check(etu_gap == 744, "R9 ETU length", etu_gap, 744);
    check(rises_per_etu == 372, "R9 card clocks per ETU", rises_per_etu, 372);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule